// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block drives a single DMA channel. Software programs a source address, a destination address and a 32-bit transfer configuration word over a small register interface. Once the configuration is marked valid and the channel trigger is set, the block moves one element at a time. For each element it issues a read request at the source address, takes the returned data and issues a write request with that data at the destination address. After each element both addresses advance by a programmed stride, and the element count held in the configuration word counts down in place.

When an element completes with the count already at zero, the descriptor is exhausted. The count wraps to all ones. Depending on the descriptor, the block then raises sticky interrupt flags, drops the trigger, clears the valid bit, or asks for the next descriptor through a reload handshake. The bus fabric, descriptor fetch, trigger routing and arbitration all sit outside the block and are represented by plain request/acknowledge ports.

The controller has four states. IDLE moves to READ when the start condition holds: valid set, trigger set, width not reserved. READ moves to WRITE on a read acknowledge. WRITE returns to READ on a write acknowledge while elements remain. At exhaustion WRITE goes to RELOAD if reload is enabled, and to IDLE otherwise. RELOAD moves to IDLE on a reload acknowledge, and the next descriptor then starts from IDLE as soon as its own start condition holds.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the configuration word reads 0, and busy, the trigger, both interrupt flags and all requests are 0. Register select codes: 0 = configuration, 1 = source address, 2 = destination address, 3 = flag clear.
- R2: A transfer starts (busy rises, then a read request appears) only when configuration bit 0 is 1, the trigger is set, and the width code in bits 9:8 is not 3. Otherwise the block stays idle.
- R3: A configuration write with bit 2 = 1 sets the trigger, and so does a high `hw_trig`. A configuration write with bit 2 = 0 leaves the trigger unchanged.
- R4: Each element consists of one read request at the source address with `rd_size` equal to the width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), followed after `rd_ack` by one write request at the destination address carrying the read data. The next read is issued only after `wr_ack`, and read and write requests are never high together.
- R5: After each element the source address advances by M × 2^width, where M is selected by bits 13:12 (0→0, 1→1, 2→2, 3→4). The destination address advances in the same way, selected by bits 15:14.
- R6: Bits 25:16 hold the element count minus one, so N+1 elements are moved. The field decrements after every element that completes with a nonzero count, and reads 0x3FF after exhaustion.
- R7: At exhaustion, bit 0 is cleared unless bit 1 (reload) is 1, in which case it is kept.
- R8: At exhaustion, bit 4 sets `irq_a` and bit 5 sets `irq_b`. Both flags are sticky until a write to select 3 with bit 0 (for `irq_a`) or bit 1 (for `irq_b`) set.
- R9: At exhaustion the trigger is cleared if bit 3 is 1 and kept if bit 3 is 0. A kept trigger lets a reloaded valid descriptor start without a new trigger.
- R10: At exhaustion with reload enabled, `reload_req` stays high until `reload_ack`. The acknowledge loads the configuration word, the source address and the destination address from `reload_cfg`, `reload_src` and `reload_dst`.
- R11: While busy, writes to the source or destination address are ignored, and so are configuration writes, except that bit 2 still sets the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 cfg, 1 src, 2 dst, 3 flag clear) |
| reg_wdata | input | 32 | Register write data |
| cfg_word | output | 32 | Live configuration word |
| hw_trig | input | 1 | Hardware trigger, sets the trigger while high |
| trig_pending | output | 1 | Channel trigger state |
| busy | output | 1 | High whenever the state is not IDLE |
| irq_a | output | 1 | Sticky interrupt flag A |
| irq_b | output | 1 | Sticky interrupt flag B |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read width code |
| rd_ack | input | 1 | Read acknowledge, qualifies rd_data |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write width code |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| reload_req | output | 1 | Request for the next descriptor |
| reload_ack | input | 1 | Next descriptor present on the reload ports |
| reload_cfg | input | 32 | Next configuration word |
| reload_src | input | AW | Next source address |
| reload_dst | input | AW | Next destination address |

## Verification
The hardest situations to reach are those at a descriptor boundary. One is a reloaded descriptor that must start on a trigger kept from its predecessor. Another is one that must wait for a fresh hardware trigger because its predecessor cleared the trigger. A third is a register write that lands mid-transfer and must leave the addresses and count intact. The bench reaches these by answering the reload handshake itself with a second descriptor, by pulsing the hardware trigger only after observing a quiet idle window, and by writing the registers while a read request is held unacknowledged between two elements. The stride arithmetic is swept over every width, source stride and destination stride code.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int DATA_W      = 32;
    localparam int CFG_W       = 32;
    // bit positions of the configuration word; software depends on them
    localparam int CFG_VALID   = 0;
    localparam int CFG_RELOAD  = 1;
    localparam int CFG_SWTRIG  = 2;
    localparam int CFG_CLRTRIG = 3;
    localparam int CFG_IRQA    = 4;
    localparam int CFG_IRQB    = 5;
    localparam int CFG_WID_LO  = 8;
    localparam int CFG_SRC_LO  = 12;
    localparam int CFG_DST_LO  = 14;
    localparam int CFG_CNT_LO  = 16;
    localparam int CFG_CNT_W   = 10;

    localparam logic [1:0] SEL_CFG   = 2'd0;
    localparam logic [1:0] SEL_SRC   = 2'd1;
    localparam logic [1:0] SEL_DST   = 2'd2;
    localparam logic [1:0] SEL_FLAGS = 2'd3;

    localparam logic [1:0] WID_RSVD  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_RELOAD = 2'd3
    } seq_state_t;
endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic [1:0]    width_code,
    input  logic [1:0]    stride_code,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] unit;
    logic [AW-1:0] inc;

    always_comb begin
        unit = AW'(1) << width_code;
        if (stride_code == 2'd0) inc = '0;
        else                     inc = unit << (stride_code - 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= load_val;
        else if (step) addr <= addr + inc;
    end

    // R5: one element moves the pointer by exactly the stride
    p_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr == $past(addr) + $past(inc)));
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              last_elem,
    input  logic              reload_en,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              wr_ack,
    input  logic              reload_ack,
    output logic              rd_req,
    output logic              wr_req,
    output logic              reload_req,
    output logic [DATA_W-1:0] wr_data,
    output logic              elem_done,
    output logic              exhaust,
    output logic              busy
);
    seq_state_t state, state_nx;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_ok) state_nx = ST_READ;
            ST_READ:   if (rd_ack)   state_nx = ST_WRITE;
            ST_WRITE:  if (wr_ack) begin
                           if (!last_elem)    state_nx = ST_READ;
                           else if (reload_en) state_nx = ST_RELOAD;
                           else               state_nx = ST_IDLE;
                       end
            ST_RELOAD: if (reload_ack) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          data_q <= '0;
        else if (state == ST_READ && rd_ack) data_q <= rd_data;
    end

    always_comb begin
        rd_req     = 1'b0;
        wr_req     = 1'b0;
        reload_req = 1'b0;
        elem_done  = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_READ:   rd_req = 1'b1;
            ST_WRITE:  begin
                           wr_req    = 1'b1;
                           elem_done = wr_ack;
                       end
            ST_RELOAD: reload_req = 1'b1;
            default:   ;
        endcase
        exhaust = elem_done && last_elem;
        busy    = (state != ST_IDLE);
        wr_data = data_q;
    end

    // R4: the two bus requests never overlap
    p_req_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    // R4: a read request is held until acknowledged
    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);
    // R4: a write follows every acknowledged read
    p_rd_to_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> wr_req);
    // R10: reload request is held until acknowledged
    p_reload_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_req && !reload_ack) |=> reload_req);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   cfg_word,
    input  logic          hw_trig,
    output logic          trig_pending,
    output logic          busy,
    output logic          irq_a,
    output logic          irq_b,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_size,
    input  logic          rd_ack,
    input  logic [31:0]   rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_size,
    output logic [31:0]   wr_data,
    input  logic          wr_ack,
    output logic          reload_req,
    input  logic          reload_ack,
    input  logic [31:0]   reload_cfg,
    input  logic [AW-1:0] reload_src,
    input  logic [AW-1:0] reload_dst
);
    localparam int LANES = 2;

    logic [CFG_W-1:0]     cfg_q;
    logic                 trig_q;
    logic                 flag_a_q, flag_b_q;
    logic                 elem_done, exhaust, start_ok, last_elem, reload_load;
    logic                 cfg_wr, flag_wr, trig_set, trig_clr;
    logic [CFG_CNT_W-1:0] cnt;
    logic [1:0]           width_code;
    logic [LANES-1:0]            lane_load;
    logic [LANES-1:0][AW-1:0]    lane_val;
    logic [LANES-1:0][AW-1:0]    lane_addr;
    logic [LANES-1:0][AW-1:0]    lane_reload;
    logic [LANES-1:0][1:0]       lane_stride;

    assign cnt        = cfg_q[CFG_CNT_LO +: CFG_CNT_W];
    assign width_code = cfg_q[CFG_WID_LO +: 2];
    assign last_elem  = (cnt == '0);
    assign start_ok   = cfg_q[CFG_VALID] && trig_q && (width_code != WID_RSVD);
    assign cfg_wr     = reg_wr && (reg_sel == SEL_CFG);
    assign flag_wr    = reg_wr && (reg_sel == SEL_FLAGS);
    assign reload_load = reload_req && reload_ack;

    dma_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok   (start_ok),
        .last_elem  (last_elem),
        .reload_en  (cfg_q[CFG_RELOAD]),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .wr_ack     (wr_ack),
        .reload_ack (reload_ack),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .reload_req (reload_req),
        .wr_data    (wr_data),
        .elem_done  (elem_done),
        .exhaust    (exhaust),
        .busy       (busy)
    );

    // configuration word: reload load, then in-place count, then software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (reload_load) begin
            cfg_q <= reload_cfg;
        end else if (elem_done) begin
            if (exhaust) begin
                cfg_q[CFG_CNT_LO +: CFG_CNT_W] <= '1;
                if (!cfg_q[CFG_RELOAD]) cfg_q[CFG_VALID] <= 1'b0;
            end else begin
                cfg_q[CFG_CNT_LO +: CFG_CNT_W] <= cnt - CFG_CNT_W'(1);
            end
        end else if (cfg_wr && !busy) begin
            cfg_q <= reg_wdata;
        end
    end

    // trigger: any set source wins over the exhaustion clear
    assign trig_set = hw_trig
                    || (cfg_wr && reg_wdata[CFG_SWTRIG])
                    || (reload_load && reload_cfg[CFG_SWTRIG]);
    assign trig_clr = exhaust && cfg_q[CFG_CLRTRIG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= (trig_q && !trig_clr) || trig_set;
    end

    // sticky flags: exhaustion set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_a_q <= 1'b0;
            flag_b_q <= 1'b0;
        end else begin
            if (exhaust && cfg_q[CFG_IRQA])    flag_a_q <= 1'b1;
            else if (flag_wr && reg_wdata[0])  flag_a_q <= 1'b0;
            if (exhaust && cfg_q[CFG_IRQB])    flag_b_q <= 1'b1;
            else if (flag_wr && reg_wdata[1])  flag_b_q <= 1'b0;
        end
    end

    assign lane_reload[0] = reload_src;
    assign lane_reload[1] = reload_dst;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [1:0] LANE_SEL = (g == 0) ? SEL_SRC : SEL_DST;
        assign lane_load[g]   = reload_load || (reg_wr && !busy && reg_sel == LANE_SEL);
        assign lane_val[g]    = reload_load ? lane_reload[g] : AW'(reg_wdata);
        assign lane_stride[g] = cfg_q[CFG_SRC_LO + 2*g +: 2];

        dma_seq_addr #(.AW(AW)) u_addr (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (lane_load[g]),
            .load_val    (lane_val[g]),
            .step        (elem_done),
            .width_code  (width_code),
            .stride_code (lane_stride[g]),
            .addr        (lane_addr[g])
        );
    end

    assign rd_addr      = lane_addr[0];
    assign wr_addr      = lane_addr[1];
    assign rd_size      = width_code;
    assign wr_size      = width_code;
    assign cfg_word     = cfg_q;
    assign trig_pending = trig_q;
    assign irq_a        = flag_a_q;
    assign irq_b        = flag_b_q;

    // R2: a transfer only begins from a valid, triggered, legal-width word
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cfg_q[CFG_VALID] && trig_q && (width_code != WID_RSVD)));
    // R6: count decrements in place after a non-final element
    p_count_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_done && !last_elem) |=>
        (cfg_q[CFG_CNT_LO +: CFG_CNT_W] == $past(cnt) - CFG_CNT_W'(1)));
    // R6: count wraps to all ones at exhaustion
    p_count_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exhaust |=> (cfg_q[CFG_CNT_LO +: CFG_CNT_W] == '1));
    // R7: valid bit drops at exhaustion without reload
    p_valid_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exhaust && !cfg_q[CFG_RELOAD]) |=> !cfg_q[CFG_VALID]);
    // R8: flag A holds until explicitly cleared
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a_q && !(flag_wr && reg_wdata[0])) |=> flag_a_q);
    // R9: clear-on-exhaustion drops the trigger when nothing sets it
    p_trig_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exhaust && cfg_q[CFG_CLRTRIG] && !hw_trig && !cfg_wr) |=> !trig_q);
    // R11: the word is untouched by software while a transfer runs
    p_busy_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !elem_done && !reload_load) |=> $stable(cfg_q));
endmodule

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   cfg_word;
    logic          hw_trig = 1'b0;
    logic          trig_pending, busy, irq_a, irq_b;
    logic          rd_req, wr_req, reload_req;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [1:0]    rd_size, wr_size;
    logic          rd_ack = 1'b0, wr_ack = 1'b0, reload_ack = 1'b0;
    logic [31:0]   rd_data = '0, wr_data;
    logic [31:0]   reload_cfg = '0;
    logic [AW-1:0] reload_src = '0, reload_dst = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_chan_seq #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cfg_word(cfg_word), .hw_trig(hw_trig),
        .trig_pending(trig_pending), .busy(busy), .irq_a(irq_a), .irq_b(irq_b),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_ack(rd_ack),
        .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_ack(wr_ack), .reload_req(reload_req),
        .reload_ack(reload_ack), .reload_cfg(reload_cfg),
        .reload_src(reload_src), .reload_dst(reload_dst)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=0x%08h exp=0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit v, input bit rl, input bit sw,
            input bit clr, input bit ia, input bit ib, input int w, input int s,
            input int d, input int cnt);
        logic [31:0] c = '0;
        c[0] = v; c[1] = rl; c[2] = sw; c[3] = clr; c[4] = ia; c[5] = ib;
        c[9:8] = w[1:0]; c[13:12] = s[1:0]; c[15:14] = d[1:0];
        c[25:16] = cnt[9:0];
        return c;
    endfunction

    function automatic logic [31:0] after_exhaust(input logic [31:0] c);
        logic [31:0] e = c;
        e[25:16] = 10'h3FF;
        if (!c[1]) e[0] = 1'b0;
        return e;
    endfunction

    function automatic logic [31:0] stride(input int w, input int code);
        if (code == 0) return 32'd0;
        return (32'd1 << w) << (code - 1);
    endfunction

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return a ^ 32'hC3A5_5A3C;
    endfunction

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_hw;
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
    endtask

    task automatic quiet(input string req, input int cycles);
        bit started = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy || rd_req) started = 1'b1;
        end
        check(!started, req, "no start while condition unmet", {31'd0, started}, 32'd0);
    endtask

    // one element: R4 handshake order, addresses and data
    task automatic do_elem(input logic [31:0] es, input logic [31:0] ed, input int w);
        int n = 0;
        while (!rd_req && n < 40) begin @(negedge clk); n++; end
        check(rd_req, "R4", "read request issued", {31'd0, rd_req}, 32'd1);
        check(rd_addr == es, "R5", "read address", rd_addr, es);
        check(rd_size == w[1:0], "R4", "read size", {30'd0, rd_size}, w);
        check(!wr_req, "R4", "no write during read", {31'd0, wr_req}, 32'd0);
        rd_data = mem_val(es); rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        check(wr_req && !rd_req, "R4", "write follows read", {30'd0, rd_req, wr_req}, 32'd1);
        check(wr_addr == ed, "R5", "write address", wr_addr, ed);
        check(wr_data == mem_val(es), "R4", "write data", wr_data, mem_val(es));
        check(wr_size == w[1:0], "R4", "write size", {30'd0, wr_size}, w);
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
    endtask

    task automatic run_desc(input logic [31:0] c, input logic [31:0] s0, input logic [31:0] d0);
        int w = int'(c[9:8]);
        int n = int'(c[25:16]);
        logic [31:0] es = s0, ed = d0;
        for (int i = 0; i <= n; i++) begin
            do_elem(es, ed, w);
            es += stride(w, int'(c[13:12]));
            ed += stride(w, int'(c[15:14]));
            if (i < n)
                check(cfg_word[25:16] == 10'(n - 1 - i), "R6", "count in place",
                      {22'd0, cfg_word[25:16]}, n - 1 - i);
        end
    endtask

    task automatic do_reload(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d);
        check(reload_req && busy, "R10", "reload request at exhaustion", {31'd0, reload_req}, 32'd1);
        reload_cfg = c; reload_src = s; reload_dst = d; reload_ack = 1'b1;
        @(negedge clk);
        reload_ack = 1'b0;
        check(!reload_req, "R10", "reload request drops", {31'd0, reload_req}, 32'd0);
        check(cfg_word == c, "R10", "reloaded word", cfg_word, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R4 watchdog expired act=1 exp=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] c, c2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check(cfg_word == 0, "R1", "cfg after reset", cfg_word, 0);
        check({busy, trig_pending, irq_a, irq_b, rd_req, wr_req, reload_req} == 0,
              "R1", "outputs after reset",
              {25'd0, busy, trig_pending, irq_a, irq_b, rd_req, wr_req, reload_req}, 0);

        // R2/R3: software trigger without valid does not start
        reg_write(2'd0, mk(0,0,1,0,0,0,0,0,0,0));
        check(trig_pending, "R3", "software trigger sets", {31'd0, trig_pending}, 1);
        quiet("R2", 10);
        reg_write(2'd1, 32'h100);
        reg_write(2'd2, 32'h200);
        c = mk(1,0,0,1,0,0,1,1,0,0);
        reg_write(2'd0, c);
        check(trig_pending, "R3", "bit2=0 leaves trigger", {31'd0, trig_pending}, 1);
        run_desc(c, 32'h100, 32'h200);
        check(cfg_word == after_exhaust(c), "R6", "single element wrap", cfg_word, after_exhaust(c));
        check(!busy && !trig_pending, "R9", "trigger cleared, idle",
              {30'd0, busy, trig_pending}, 0);

        // R2/R3: valid but no trigger, then hardware trigger
        reg_write(2'd1, 32'h300);
        reg_write(2'd2, 32'h400);
        c = mk(1,0,0,1,0,0,2,0,1,0);
        reg_write(2'd0, c);
        quiet("R2", 10);
        pulse_hw();
        run_desc(c, 32'h300, 32'h400);
        check(cfg_word == after_exhaust(c), "R7", "valid cleared", cfg_word, after_exhaust(c));

        // R2: reserved width never starts
        reg_write(2'd0, mk(1,0,1,1,0,0,3,1,1,0));
        quiet("R2", 10);

        // R5/R6/R8 sweep over width and both stride codes
        for (int w = 0; w < 3; w++)
            for (int s = 0; s < 4; s++)
                for (int d = 0; d < 4; d++) begin
                    logic [31:0] s0 = 32'h0001_0000 + 32'(w * 4096 + s * 256 + d * 16);
                    logic [31:0] d0 = 32'h8000_0000 + 32'(w * 4096 + s * 256 + d * 16);
                    bit ia = ((s + d) % 2) == 0;
                    bit ib = ((w + d) % 2) == 1;
                    c = mk(1,0,1,1,ia,ib,w,s,d,2);
                    reg_write(2'd1, s0);
                    reg_write(2'd2, d0);
                    reg_write(2'd0, c);
                    run_desc(c, s0, d0);
                    check(cfg_word == after_exhaust(c), "R6", "sweep final word",
                          cfg_word, after_exhaust(c));
                    check(irq_a == ia && irq_b == ib, "R8", "sweep flags",
                          {30'd0, irq_a, irq_b}, {30'd0, ia, ib});
                    check(!busy && !trig_pending, "R9", "sweep idle, trigger clear",
                          {30'd0, busy, trig_pending}, 0);
                    reg_write(2'd3, 32'd3);
                    check(!irq_a && !irq_b, "R8", "flags cleared",
                          {30'd0, irq_a, irq_b}, 0);
                end

        // R11: writes during a transfer are ignored
        reg_write(2'd1, 32'h2000);
        reg_write(2'd2, 32'h3000);
        c = mk(1,0,1,1,0,0,2,1,2,1);
        reg_write(2'd0, c);
        do_elem(32'h2000, 32'h3000, 2);
        reg_write(2'd0, 32'h03FF_F0F1);
        reg_write(2'd1, 32'hDEAD_0000);
        reg_write(2'd2, 32'hBEEF_0000);
        check(cfg_word[25:16] == 10'd0, "R11", "count kept after busy write",
              {22'd0, cfg_word[25:16]}, 0);
        do_elem(32'h2004, 32'h3008, 2);
        check(cfg_word == after_exhaust(c), "R11", "word after busy writes",
              cfg_word, after_exhaust(c));

        // R10/R9/R7: reload with trigger kept
        reg_write(2'd1, 32'h4000);
        reg_write(2'd2, 32'h5000);
        c = mk(1,1,1,0,1,0,0,1,1,0);
        reg_write(2'd0, c);
        run_desc(c, 32'h4000, 32'h5000);
        check(cfg_word == after_exhaust(c), "R7", "valid kept with reload",
              cfg_word, after_exhaust(c));
        check(trig_pending && irq_a, "R9", "trigger kept, flag A set",
              {30'd0, trig_pending, irq_a}, 3);
        c2 = mk(1,0,0,1,0,1,1,2,0,1);
        do_reload(c2, 32'h6000, 32'h7000);
        run_desc(c2, 32'h6000, 32'h7000);
        check(cfg_word == after_exhaust(c2), "R10", "chained word", cfg_word, after_exhaust(c2));
        check(irq_a && irq_b && !trig_pending, "R8", "both flags after chain",
              {29'd0, irq_a, irq_b, trig_pending}, 6);
        reg_write(2'd3, 32'd1);
        check(!irq_a && irq_b, "R8", "clear A only", {30'd0, irq_a, irq_b}, 1);
        reg_write(2'd3, 32'd2);
        check(!irq_b, "R8", "clear B", {31'd0, irq_b}, 0);

        // R9/R10: reload with trigger cleared needs a new trigger
        reg_write(2'd1, 32'h100);
        reg_write(2'd2, 32'h180);
        c = mk(1,1,1,1,0,0,2,0,0,0);
        reg_write(2'd0, c);
        run_desc(c, 32'h100, 32'h180);
        c2 = mk(1,0,0,1,0,0,0,1,1,0);
        do_reload(c2, 32'h40, 32'h50);
        check(!trig_pending, "R9", "trigger cleared before reload start",
              {31'd0, trig_pending}, 0);
        quiet("R9", 10);
        pulse_hw();
        run_desc(c2, 32'h40, 32'h50);
        check(cfg_word == after_exhaust(c2), "R10", "second reload word",
              cfg_word, after_exhaust(c2));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule